// File: doc/BRIEF.md
# Ready-Polled NOR Flash Erase and Program Sequencer

This block drives a NOR flash device that takes commands as two writes and reports progress through a status byte. A single request either erases one block at a given byte offset or programs a run of bytes, one byte at a time, starting at a given offset. The bytes to be programmed arrive on a valid/ready stream. After each erase, and after each programmed byte, the sequencer reads the status byte at the same offset. It keeps reading until the ready bit is set, then checks the remaining status bits for a device fault.

The memory side is a synchronous port. A read strobe returns its data on the next cycle. Writes complete in the cycle they are strobed. Erase and program each have their own polling limit, given in clock cycles. When the sequence ends, `done` pulses once. The error flag, the error code and the status byte that caused a failure stay available until the next request is accepted. A mode input shifts the command address for devices wired as 16-bit parts.

Top module: `nor_seq`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `done`=0, `err`=0, `err_code`=0, `mem_we`=0 and `mem_re`=0.
- R2: An erase writes 0xFF at the command address, then 0x20 at the request offset, then 0xD0 at the request offset. It then polls. If the final status is clean, it writes 0xFF at the command address once more and finishes with `err`=0.
- R3: A program of N bytes does the following for byte i, counting from 0. It writes 0xFF at the command address, then 0x40 at offset+i, then the data byte at offset+i, then polls. The address moves on by one only after a byte completes cleanly. A single 0xFF at the command address follows the last byte.
- R4: Polling reads the status at the address of the operation in progress and repeats while status bit 7 (ready) is 0. One read is made for every busy status, plus one read that returns ready.
- R5: A ready status whose bits 6:0 are not all zero ends the operation at once. The result is `err`=1, `err_code`=1 (device fault) and `fail_status` equal to that byte. No further writes are made, including the exit 0xFF and any remaining bytes.
- R6: A poll counter is cleared when the confirm or data write is made. It counts every cycle spent polling, so the n-th status check sees the value 2n-1. If that value exceeds the limit for the current operation (`erase_limit` for an erase, `prog_limit` for a program) and the status is not ready, the operation aborts. The result is `err_code`=2 (timeout) and `fail_status` equal to the busy status byte. No exit write is made.
- R7: The command address is CMD_ADDR (default 0x555) when `mode16`=0 and CMD_ADDR shifted left by one (0xAAA) when `mode16`=1. Block and data offsets are never shifted.
- R8: During a program, the data write waits for `wr_byte_valid`. No write is made while the stream is empty, and each byte is consumed exactly once.
- R9: A program request of length 0 finishes with `done` and `err`=0 and makes no memory access.
- R10: `done` is high for exactly one cycle per request. `err`, `err_code` and `fail_status` hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_prog | input | 1 | 1 = program bytes, 0 = erase block |
| req_offset | input | AW | Byte offset of the block or of the first byte |
| req_len | input | LW | Number of bytes to program |
| mode16 | input | 1 | Shift the command address for 16-bit devices |
| wr_byte_valid | input | 1 | Program data byte present |
| wr_byte | input | 8 | Program data byte |
| wr_byte_ready | output | 1 | Data byte taken this cycle if valid |
| erase_limit | input | TW | Polling limit for an erase, in cycles |
| prog_limit | input | TW | Polling limit for one byte, in cycles |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe, data due next cycle |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request failed |
| err_code | output | 2 | 0 none, 1 device fault, 2 timeout |
| fail_status | output | 8 | Status byte that ended a failed request |

## Verification
The hardest condition to reach is a timeout that lands exactly on the limit boundary. The limit is compared with a counter that advances twice per status check, so the check that aborts depends on the parity of the limit. The bench reaches it with a device model that returns a programmable number of busy statuses before ready. It sets that count just above or just below the boundary under different erase and program limits. The bench works out the expected number of reads from the R6 rule itself. A fault on the first byte of a multi-byte program checks that the remaining bytes are abandoned. A held-off data stream checks that nothing is written while the stream is empty.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_SETUP, S_CONF, S_PRD, S_PCHK, S_EXIT, S_FIN
  } seq_state_t;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_DEV  = 2'd1;
  localparam logic [1:0] ERR_TMO  = 2'd2;

  localparam logic [7:0] OP_RESET   = 8'hFF;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_PROG    = 8'h40;

  function automatic logic stat_ready(input logic [7:0] s);
    return s[7];
  endfunction

  function automatic logic stat_fault(input logic [7:0] s);
    return s[7] && (s[6:0] != 7'd0);
  endfunction

endpackage

// File: rtl/nor_status_chk.sv
module nor_status_chk
  import nor_seq_pkg::*;
(
  input  logic [7:0] status,
  output logic       rdy,
  output logic       fault
);
  always_comb begin
    rdy   = stat_ready(status);
    fault = stat_fault(status);
  end
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (run && cnt != '1)  cnt <= cnt + TW'(1);
  end

  assign expired = cnt > limit;

  // R6: the counter saturates rather than wrapping back under the limit
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && cnt == '1) |=> cnt == '1);
endmodule

// File: rtl/nor_seq.sv
module nor_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LW       = 16,
  parameter int TW       = 16,
  parameter int CMD_ADDR = 'h555
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_prog,
  input  logic [AW-1:0] req_offset,
  input  logic [LW-1:0] req_len,
  input  logic          mode16,
  input  logic          wr_byte_valid,
  input  logic [7:0]    wr_byte,
  output logic          wr_byte_ready,
  input  logic [TW-1:0] erase_limit,
  input  logic [TW-1:0] prog_limit,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_code,
  output logic [7:0]    fail_status
);
  localparam logic [AW-1:0] CMD_BASE = AW'(CMD_ADDR);

  function automatic logic [AW-1:0] cmd_addr(input logic wide);
    return wide ? {CMD_BASE[AW-2:0], 1'b0} : CMD_BASE;
  endfunction

  seq_state_t    st;
  logic          op_prog;
  logic [AW-1:0] cur_ofs;
  logic [LW-1:0] remain;

  // named internal events
  logic stat_rdy, stat_fault, tmo_exp;
  logic accept, chk_fault, chk_ok, chk_tmo, last_byte;

  nor_status_chk u_stat (
    .status (mem_rdata),
    .rdy    (stat_rdy),
    .fault  (stat_fault)
  );

  nor_poll_timer #(.TW(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (st == S_CONF),
    .run     (st == S_PRD || st == S_PCHK),
    .limit   (op_prog ? prog_limit : erase_limit),
    .expired (tmo_exp)
  );

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_FIN);
  assign accept    = req_valid && req_ready;
  assign last_byte = !op_prog || (remain == LW'(1));
  assign chk_fault = (st == S_PCHK) && stat_fault;
  assign chk_ok    = (st == S_PCHK) && stat_rdy && !stat_fault;
  assign chk_tmo   = (st == S_PCHK) && !stat_rdy && tmo_exp;

  always_comb begin
    mem_we        = 1'b0;
    mem_re        = 1'b0;
    mem_addr      = cur_ofs;
    mem_wdata     = OP_RESET;
    wr_byte_ready = 1'b0;
    case (st)
      S_RST, S_EXIT: begin
        mem_we   = 1'b1;
        mem_addr = cmd_addr(mode16);
      end
      S_SETUP: begin
        mem_we    = 1'b1;
        mem_wdata = op_prog ? OP_PROG : OP_ERASE;
      end
      S_CONF: begin
        if (op_prog) begin
          wr_byte_ready = 1'b1;
          mem_we        = wr_byte_valid;
          mem_wdata     = wr_byte;
        end else begin
          mem_we    = 1'b1;
          mem_wdata = OP_CONFIRM;
        end
      end
      S_PRD:   mem_re = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_prog     <= 1'b0;
      cur_ofs     <= '0;
      remain      <= '0;
      err         <= 1'b0;
      err_code    <= ERR_NONE;
      fail_status <= 8'h00;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          op_prog     <= req_prog;
          cur_ofs     <= req_offset;
          remain      <= req_len;
          err         <= 1'b0;
          err_code    <= ERR_NONE;
          fail_status <= 8'h00;
          st          <= (req_prog && req_len == '0) ? S_FIN : S_RST;
        end
        S_RST:   st <= S_SETUP;
        S_SETUP: st <= S_CONF;
        S_CONF:  if (!op_prog || wr_byte_valid) st <= S_PRD;
        S_PRD:   st <= S_PCHK;
        S_PCHK: begin
          if (chk_fault) begin
            err <= 1'b1; err_code <= ERR_DEV; fail_status <= mem_rdata;
            st  <= S_FIN;
          end else if (chk_ok) begin
            if (last_byte) st <= S_EXIT;
            else begin
              cur_ofs <= cur_ofs + AW'(1);
              remain  <= remain - LW'(1);
              st      <= S_RST;
            end
          end else if (chk_tmo) begin
            err <= 1'b1; err_code <= ERR_TMO; fail_status <= mem_rdata;
            st  <= S_FIN;
          end else st <= S_PRD;
        end
        S_EXIT:  st <= S_FIN;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1: nothing touches memory while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_we && !mem_re));
  // R5: a latched device fault is a ready status with fault bits
  a_r5_fault_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_DEV) |-> (fail_status[7] && fail_status[6:0] != 7'd0));
  // R6: a timeout is only taken on a busy status
  a_r6_tmo_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == ERR_TMO) |-> !fail_status[7]);
  // R3: the program address steps by one after a clean byte
  a_r3_ofs_step: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_ok && !last_byte) |=> cur_ofs == $past(cur_ofs) + AW'(1));
  // R8: no data write while the stream is empty
  a_r8_wait_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_ready && !wr_byte_valid) |-> !mem_we);
  // R4: a read strobe is never combined with a write
  a_r4_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

// File: tb/tb_nor_seq.sv
module tb_nor_seq;
  localparam int AW = 16, LW = 16, TW = 16;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic          req_valid = 0, req_prog = 0, mode16 = 0;
  logic [AW-1:0] req_offset = '0;
  logic [LW-1:0] req_len = '0;
  logic          wr_byte_valid = 0;
  logic [7:0]    wr_byte = 0;
  logic [TW-1:0] erase_limit = 16'd100, prog_limit = 16'd100;
  logic          req_ready, wr_byte_ready, mem_we, mem_re, done, err;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata, fail_status;
  logic [1:0]    err_code;

  nor_seq dut (.*);

  int total = 0, bad = 0;

  // device model and logs
  logic [AW-1:0] wa [0:63];
  logic [7:0]    wd [0:63];
  int wn = 0, rd_cnt = 0, reads_left = 0, busy_cfg = 0, rd_bad = 0;
  logic [7:0] busy_val = 8'h00, final_val = 8'h80;
  logic [AW-1:0] last_wa = '0;
  logic log_clr = 0;
  // byte stream
  logic [7:0] feed_dat [0:15];
  int feed_idx = 0, feed_n = 0;
  logic feed_on = 0, feed_stall = 0, feed_clr = 0, gap_t = 0;

  always @(posedge clk) begin
    if (log_clr) begin
      wn <= 0; rd_cnt <= 0; rd_bad <= 0;
    end else begin
      if (mem_we) begin
        if (wn < 64) begin wa[wn] <= mem_addr; wd[wn] <= mem_wdata; end
        wn <= wn + 1; last_wa <= mem_addr; reads_left <= busy_cfg;
      end
      if (mem_re) begin
        rd_cnt <= rd_cnt + 1;
        if (mem_addr != last_wa) rd_bad <= rd_bad + 1;
        if (reads_left > 0) begin mem_rdata <= busy_val; reads_left <= reads_left - 1; end
        else mem_rdata <= final_val;
      end
    end
    if (feed_clr) feed_idx <= 0;
    else if (wr_byte_valid && wr_byte_ready) feed_idx <= feed_idx + 1;
  end

  initial forever begin
    @(negedge clk);
    gap_t = ~gap_t;
    wr_byte_valid = feed_on && (feed_idx < feed_n) && (!feed_stall || gap_t);
    wr_byte = feed_dat[feed_idx & 15];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] cmd_a(input logic wide);
    return wide ? AW'('h555 * 2) : AW'('h555);
  endfunction

  // R6 rule: check n sees 2n-1; returns reads, sets tmo
  function automatic int exp_reads(input int busy, input int lim, output bit tmo);
    for (int n = 1; n < 100000; n++) begin
      if (n > busy) begin tmo = 0; return n; end
      if (2*n - 1 > lim) begin tmo = 1; return n; end
    end
    tmo = 1; return 0;
  endfunction

  task automatic clear_logs();
    @(negedge clk); log_clr = 1; feed_clr = 1;
    @(negedge clk); log_clr = 0; feed_clr = 0;
  endtask

  task automatic run_op(input bit prog, input logic [AW-1:0] ofs, input int len);
    @(negedge clk);
    req_valid = 1; req_prog = prog; req_offset = ofs; req_len = LW'(len);
    @(negedge clk);
    req_valid = 0;
    while (!done) @(negedge clk);
  endtask

  task automatic chk_wr(input int i, input logic [AW-1:0] a, input logic [7:0] d, input string req);
    chk(wa[i] == a, req, int'(wa[i]), int'(a));
    chk(wd[i] == d, req, int'(wd[i]), int'(d));
  endtask

  task automatic t_reset();
    chk(req_ready == 1 && done == 0 && err == 0 && err_code == 0, "R1", {req_ready, done, err, err_code}, 5'b10000);
    chk(mem_we == 0 && mem_re == 0, "R1", {mem_we, mem_re}, 0);
  endtask

  task automatic t_erase(input bit m16, input logic [AW-1:0] ofs, input int busy);
    bit tmo; int n;
    mode16 = m16; busy_cfg = busy; busy_val = 8'h00; final_val = 8'h80;
    clear_logs();
    n = exp_reads(busy, int'(erase_limit), tmo);
    run_op(0, ofs, 0);
    chk(err == 0 && err_code == 0, "R2", err_code, 0);
    chk(wn == 4, "R2", wn, 4);
    chk_wr(0, cmd_a(m16), 8'hFF, m16 ? "R7" : "R2");
    chk_wr(1, ofs, 8'h20, "R2");
    chk_wr(2, ofs, 8'hD0, "R2");
    chk_wr(3, cmd_a(m16), 8'hFF, m16 ? "R7" : "R2");
    chk(rd_cnt == n && !tmo, "R4", rd_cnt, n);
    chk(rd_bad == 0, "R4", rd_bad, 0);
  endtask

  task automatic t_program(input bit m16, input logic [AW-1:0] ofs, input int len, input int busy, input bit stall);
    bit tmo; int n;
    mode16 = m16; busy_cfg = busy; busy_val = 8'h00; final_val = 8'h80;
    clear_logs();
    for (int i = 0; i < len; i++) feed_dat[i] = 8'(i * 37 + 8'h5A);
    feed_n = len; feed_stall = stall; feed_on = 1;
    n = exp_reads(busy, int'(prog_limit), tmo);
    run_op(1, ofs, len);
    feed_on = 0;
    chk(err == 0, "R3", err_code, 0);
    chk(wn == 3*len + 1, "R3", wn, 3*len + 1);
    for (int i = 0; i < len; i++) begin
      chk_wr(3*i,   cmd_a(m16), 8'hFF, "R3");
      chk_wr(3*i+1, ofs + AW'(i), 8'h40, "R3");
      chk_wr(3*i+2, ofs + AW'(i), feed_dat[i], stall ? "R8" : "R3");
    end
    chk_wr(3*len, cmd_a(m16), 8'hFF, "R3");
    chk(rd_cnt == n*len, "R4", rd_cnt, n*len);
    chk(feed_idx == len, "R8", feed_idx, len);
  endtask

  task automatic t_stream_hold();
    mode16 = 0; busy_cfg = 0; final_val = 8'h80;
    clear_logs();
    feed_dat[0] = 8'hC3; feed_n = 1; feed_stall = 0; feed_on = 0;
    @(negedge clk); req_valid = 1; req_prog = 1; req_offset = 16'h0300; req_len = 1;
    @(negedge clk); req_valid = 0;
    repeat (20) @(negedge clk);
    chk(wn == 2, "R8", wn, 2);
    chk(mem_we == 0 && wr_byte_ready == 1, "R8", {mem_we, wr_byte_ready}, 1);
    feed_on = 1;
    while (!done) @(negedge clk);
    feed_on = 0;
    chk(wn == 4 && wd[2] == 8'hC3, "R8", int'(wd[2]), 8'hC3);
  endtask

  task automatic t_fault();
    busy_cfg = 2; busy_val = 8'h00; final_val = 8'hA0; mode16 = 0;
    clear_logs();
    for (int i = 0; i < 3; i++) feed_dat[i] = 8'(i + 1);
    feed_n = 3; feed_stall = 0; feed_on = 1;
    run_op(1, 16'h0400, 3);
    feed_on = 0;
    chk(err == 1 && err_code == 2'd1, "R5", err_code, 1);
    chk(fail_status == 8'hA0, "R5", fail_status, 8'hA0);
    chk(wn == 3, "R5", wn, 3);
    @(negedge clk);
    chk(done == 0, "R10", done, 0);
    repeat (5) @(negedge clk);
    chk(err == 1 && err_code == 2'd1 && fail_status == 8'hA0, "R10", fail_status, 8'hA0);
    chk(wn == 3 && mem_we == 0, "R5", wn, 3);
  endtask

  task automatic t_timeout(input bit prog, input int lim);
    bit tmo; int n;
    busy_cfg = 100000; busy_val = 8'h08; final_val = 8'h80; mode16 = 0;
    if (prog) prog_limit = TW'(lim); else erase_limit = TW'(lim);
    clear_logs();
    feed_dat[0] = 8'h11; feed_n = 1; feed_stall = 0; feed_on = 1;
    n = exp_reads(busy_cfg, lim, tmo);
    run_op(prog, 16'h0500, 1);
    feed_on = 0;
    chk(err == 1 && err_code == 2'd2 && tmo, "R6", err_code, 2);
    chk(fail_status == 8'h08, "R6", fail_status, 8'h08);
    chk(rd_cnt == n, "R6", rd_cnt, n);
    chk(wn == 3, "R6", wn, 3);
  endtask

  task automatic t_limits_split();
    // erase limit generous, program limit tight, same busy count
    erase_limit = 16'd20; prog_limit = 16'd7;
    t_erase(0, 16'h0600, 5);
    busy_cfg = 5; busy_val = 8'h00; final_val = 8'h80;
    clear_logs();
    feed_dat[0] = 8'h22; feed_n = 1; feed_on = 1; feed_stall = 0;
    run_op(1, 16'h0700, 1);
    feed_on = 0;
    chk(err_code == 2'd2, "R6", err_code, 2);
    chk(rd_cnt == 5, "R6", rd_cnt, 5);
    erase_limit = 16'd100; prog_limit = 16'd100;
  endtask

  task automatic t_zero_len();
    clear_logs();
    run_op(1, 16'h0800, 0);
    chk(err == 0 && err_code == 0, "R9", err_code, 0);
    chk(wn == 0 && rd_cnt == 0, "R9", wn, 0);
    @(negedge clk);
    chk(done == 0 && req_ready == 1, "R10", done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase(0, 16'h1000, 0);
    t_erase(0, 16'h2040, 3);
    t_erase(1, 16'h0123, 1);
    t_program(0, 16'h0200, 3, 0, 0);
    t_program(1, 16'h0210, 4, 2, 1);
    t_program(0, 16'h02FE, 2, 4, 1);
    t_stream_hold();
    t_fault();
    t_timeout(1, 7);
    t_timeout(1, 8);
    t_timeout(0, 10);
    t_limits_split();
    t_zero_len();
    t_erase(0, 16'h3000, 2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule